// File: doc/BRIEF.md
# DS3 Transmit Overhead Override Stage

This block is the final overhead stage of a DS3 transmit path. It sits after error insertion and lets an external agent replace any overhead bit of the outgoing M-frame. The stream arrives one bit per enabled clock. An upstream framer tags each bit as payload or overhead and gives an identifier for each overhead position. For every valid overhead position the block raises a strobe, shows the position identifier and marks the first position of the M-frame. External logic can answer in the same cycle with a data bit and an enable.

At the two parity positions the external bit is not a replacement. It is XORed into the internally computed bit as an error mask. At every other overhead position an enabled external bit overwrites the incoming bit. Payload bits always pass through untouched. Every bit leaves the block exactly one clock after it enters.

The position identifier is six bits wide:
- Bits [5:3] hold the subframe number, 0 to 6.
- Bits [2:0] hold the slot within that subframe, 0 to 7.
- Slot 0 of subframes 0 to 6 carries X1, X2, P1, P2, M1, M2 and M3, in that order.
- Slots 1 to 7 carry the F and C bits.
- Subframe number 7 is not a legal position.

Top module: `ds3ov_override`

## Requirements
- R1: While reset is asserted, and until the internal synchronised reset is released, out_vld, out_dat and out_sof are 0.
- R2: out_vld is 1 exactly one clock after a cycle with in_vld = 1 and 0 otherwise. When in_vld = 0, out_dat keeps its previous value.
- R3: A bit with in_ohp = 0 is a payload bit. It appears on out_dat one clock later equal to in_dat, whatever ext_en and ext_dat are.
- R4: At a valid overhead position other than subframe 2 or 3 slot 0, with ext_en = 1, out_dat one clock later equals ext_dat.
- R5: At the parity positions (in_pos = 6'o20 and 6'o30), with ext_en = 1, out_dat one clock later equals in_dat XOR ext_dat.
- R6: At any valid overhead position with ext_en = 0, out_dat one clock later equals in_dat.
- R7: oh_stb is 1 in the same cycle exactly when in_vld, in_ohp and a legal position (subframe field below 7) coincide. oh_pos shows in_pos while oh_stb is 1 and is 0 otherwise.
- R8: oh_sof is 1 in the same cycle exactly when oh_stb is 1 and in_pos = 0 (X1). out_sof is 1 one clock later, aligned with that bit on out_dat, and 0 otherwise.
- R9: An overhead-flagged bit whose subframe field is 7 is handled as payload. It raises no strobe, and in_dat passes through regardless of ext_en and ext_dat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Bit enable for the incoming stream |
| in_dat | input | 1 | Incoming DS3 bit after error insertion |
| in_ohp | input | 1 | Incoming bit is an overhead position |
| in_pos | input | 6 | Overhead position identifier {subframe, slot} |
| ext_en | input | 1 | External overhead enable for this position |
| ext_dat | input | 1 | External overhead bit or parity mask |
| oh_stb | output | 1 | Overhead position present this cycle |
| oh_pos | output | 6 | Position identifier shown to external logic |
| oh_sof | output | 1 | First overhead position (X1) of the M-frame |
| out_vld | output | 1 | Outgoing bit enable |
| out_dat | output | 1 | Outgoing DS3 bit |
| out_sof | output | 1 | Outgoing bit is the X1 position |

## Verification
On every cycle, the bound checker enforces several rules:
- the one-clock latency of the bit enable;
- that out_dat holds during idle cycles;
- that payload passes through unchanged;
- full replacement at ordinary overhead positions and XOR masking at the two parity positions;
- that the strobes stay consistent with one another.

The bench sweeps all 64 identifier codes under every combination of data, enable and external bit. Only this sweep shows two things: that the strobe rises exactly at the legal positions, and that the illegal subframe code 7 behaves as payload. The bench also shows the reset state and the values held across idle gaps.

// File: rtl/ds3ov_pkg.sv
package ds3ov_pkg;

  localparam int unsigned SUB_W   = 3;
  localparam int unsigned SLOT_W  = 3;
  localparam int unsigned POS_W   = SUB_W + SLOT_W;

  typedef enum logic [1:0] {
    MRG_PASS    = 2'd0,
    MRG_REPLACE = 2'd1,
    MRG_MASK    = 2'd2
  } mrg_sel_e;

  typedef struct packed {
    logic stb;
    logic sof;
    logic par;
  } pos_info_t;

endpackage

// File: rtl/ds3ov_rst_sync.sv
module ds3ov_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ds3ov_pos_decode.sv
module ds3ov_pos_decode
  import ds3ov_pkg::*;
#(
  parameter int unsigned SUB_BITS    = 3,
  parameter int unsigned SLOT_BITS   = 3,
  parameter int unsigned NUM_SUB     = 7,
  parameter int unsigned PAR_SUB_LO  = 2,
  parameter int unsigned PAR_SUB_HI  = 3,
  localparam int unsigned PW         = SUB_BITS + SLOT_BITS
) (
  input  logic          in_vld,
  input  logic          in_ohp,
  input  logic [PW-1:0] in_pos,
  output pos_info_t     info,
  output logic [PW-1:0] pos_shown
);

  logic [SUB_BITS-1:0]  sub_f;
  logic [SLOT_BITS-1:0] slot_f;
  logic                 legal;
  logic                 par_sub;

  always_comb begin
    sub_f   = in_pos[PW-1:SLOT_BITS];
    slot_f  = in_pos[SLOT_BITS-1:0];
    legal   = (32'(sub_f) < NUM_SUB);
    par_sub = (32'(sub_f) >= PAR_SUB_LO) && (32'(sub_f) <= PAR_SUB_HI);

    info.stb = in_vld && in_ohp && legal;
    info.sof = info.stb && (sub_f == '0) && (slot_f == '0);
    info.par = info.stb && par_sub && (slot_f == '0);

    pos_shown = info.stb ? in_pos : '0;
  end

endmodule

// File: rtl/ds3ov_merge.sv
module ds3ov_merge
  import ds3ov_pkg::*;
(
  input  pos_info_t info,
  input  logic      in_dat,
  input  logic      ext_en,
  input  logic      ext_dat,
  output logic      nxt_dat
);

  mrg_sel_e sel;

  always_comb begin
    if (!info.stb || !ext_en) begin
      sel = MRG_PASS;
    end else if (info.par) begin
      sel = MRG_MASK;
    end else begin
      sel = MRG_REPLACE;
    end
  end

  always_comb begin
    unique case (sel)
      MRG_REPLACE: nxt_dat = ext_dat;
      MRG_MASK:    nxt_dat = in_dat ^ ext_dat;
      default:     nxt_dat = in_dat;
    endcase
  end

endmodule

// File: rtl/ds3ov_out_reg.sv
module ds3ov_out_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic cen,
  input  logic nxt_dat,
  input  logic nxt_sof,
  output logic out_vld,
  output logic out_dat,
  output logic out_sof
);

  logic vld_d, dat_d, sof_d;
  logic vld_q, dat_q, sof_q;

  always_comb begin
    vld_d = cen;
    sof_d = cen && nxt_sof;
    dat_d = cen ? nxt_dat : dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= 1'b0;
      sof_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_d;
      sof_q <= sof_d;
    end
  end

  assign out_vld = vld_q;
  assign out_dat = dat_q;
  assign out_sof = sof_q;

endmodule

// File: rtl/ds3ov_override.sv
module ds3ov_override
  import ds3ov_pkg::*;
#(
  parameter int unsigned SUB_BITS    = SUB_W,
  parameter int unsigned SLOT_BITS   = SLOT_W,
  parameter int unsigned NUM_SUB     = 7,
  parameter int unsigned PAR_SUB_LO  = 2,
  parameter int unsigned PAR_SUB_HI  = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PW         = SUB_BITS + SLOT_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic          in_dat,
  input  logic          in_ohp,
  input  logic [PW-1:0] in_pos,
  input  logic          ext_en,
  input  logic          ext_dat,
  output logic          oh_stb,
  output logic [PW-1:0] oh_pos,
  output logic          oh_sof,
  output logic          out_vld,
  output logic          out_dat,
  output logic          out_sof
);

  logic      rst_sync_n;
  pos_info_t info;
  logic      nxt_dat;

  ds3ov_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ds3ov_pos_decode #(
    .SUB_BITS   (SUB_BITS),
    .SLOT_BITS  (SLOT_BITS),
    .NUM_SUB    (NUM_SUB),
    .PAR_SUB_LO (PAR_SUB_LO),
    .PAR_SUB_HI (PAR_SUB_HI)
  ) u_pos_decode (
    .in_vld    (in_vld),
    .in_ohp    (in_ohp),
    .in_pos    (in_pos),
    .info      (info),
    .pos_shown (oh_pos)
  );

  ds3ov_merge u_merge (
    .info    (info),
    .in_dat  (in_dat),
    .ext_en  (ext_en),
    .ext_dat (ext_dat),
    .nxt_dat (nxt_dat)
  );

  ds3ov_out_reg u_out_reg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cen     (in_vld),
    .nxt_dat (nxt_dat),
    .nxt_sof (info.sof),
    .out_vld (out_vld),
    .out_dat (out_dat),
    .out_sof (out_sof)
  );

  assign oh_stb = info.stb;
  assign oh_sof = info.sof;

endmodule

// File: rtl/ds3ov_override_chk.sv
module ds3ov_override_chk #(
  parameter int unsigned PW = 6
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          in_vld,
  input logic          in_dat,
  input logic          in_ohp,
  input logic [PW-1:0] in_pos,
  input logic          ext_en,
  input logic          ext_dat,
  input logic          oh_stb,
  input logic          oh_sof,
  input logic          out_vld,
  input logic          out_dat,
  input logic          out_sof
);

  logic par_pos;
  assign par_pos = (in_pos == 6'o20) || (in_pos == 6'o30);

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_vld |=> out_vld); // R2
  AST_VLD_DROPS: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_vld |=> !out_vld); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_vld |=> $stable(out_dat)); // R2
  AST_PAYLOAD_PASS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_vld && !in_ohp) |=> (out_dat == $past(in_dat))); // R3
  AST_EXT_REPLACE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (oh_stb && ext_en && !par_pos) |=> (out_dat == $past(ext_dat))); // R4
  AST_PAR_MASK: assert property (@(posedge clk) disable iff (!rst_q_n)
    (oh_stb && ext_en && par_pos) |=> (out_dat == ($past(in_dat) ^ $past(ext_dat)))); // R5
  AST_NO_EXT_PASS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (oh_stb && !ext_en) |=> (out_dat == $past(in_dat))); // R6
  AST_STB_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_q_n)
    oh_stb |-> (in_vld && in_ohp)); // R7
  AST_SOF_IN_STB: assert property (@(posedge clk) disable iff (!rst_q_n)
    oh_sof |-> (oh_stb && in_pos == '0)); // R8
  AST_SOF_ALIGN: assert property (@(posedge clk) disable iff (!rst_q_n)
    oh_sof |=> (out_sof && out_vld)); // R8
  AST_SOF_ONLY_AFTER: assert property (@(posedge clk) disable iff (!rst_q_n)
    !oh_sof |=> !out_sof); // R8

endmodule

bind ds3ov_override ds3ov_override_chk #(.PW(PW)) u_chk (
  .clk     (clk),
  .rst_q_n (rst_sync_n),
  .in_vld  (in_vld),
  .in_dat  (in_dat),
  .in_ohp  (in_ohp),
  .in_pos  (in_pos),
  .ext_en  (ext_en),
  .ext_dat (ext_dat),
  .oh_stb  (oh_stb),
  .oh_sof  (oh_sof),
  .out_vld (out_vld),
  .out_dat (out_dat),
  .out_sof (out_sof)
);

// File: tb/ds3ov_override_bench.sv
module ds3ov_override_bench;

  logic       clk;
  logic       rst_n;
  logic       in_vld, in_dat, in_ohp, ext_en, ext_dat;
  logic [5:0] in_pos;
  logic       oh_stb, oh_sof, out_vld, out_dat, out_sof;
  logic [5:0] oh_pos;

  int checks;
  int errors;
  int cycles;
  bit done;

  ds3ov_override u_ds3ov_override (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_dat  (in_dat),
    .in_ohp  (in_ohp),
    .in_pos  (in_pos),
    .ext_en  (ext_en),
    .ext_dat (ext_dat),
    .oh_stb  (oh_stb),
    .oh_pos  (oh_pos),
    .oh_sof  (oh_sof),
    .out_vld (out_vld),
    .out_dat (out_dat),
    .out_sof (out_sof)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input bit v, input bit d, input bit o, input int p,
                       input bit e, input bit x);
    @(negedge clk);
    in_vld  = v;
    in_dat  = d;
    in_ohp  = o;
    in_pos  = 6'(p);
    ext_en  = e;
    ext_dat = x;
  endtask

  // One bit through the block; expected values from the position code arithmetic.
  task automatic send(input bit d, input bit o, input int p, input bit e, input bit x);
    int  sub;
    int  slot;
    bit  legal;
    bit  par;
    bit  stb_x;
    bit  sof_x;
    bit  out_x;
    sub   = p / 8;
    slot  = p % 8;
    legal = (sub < 7);
    par   = (slot == 0) && (sub == 2 || sub == 3);
    stb_x = o && legal;
    sof_x = stb_x && (p == 0);
    if (!stb_x || !e) out_x = d;      // R3 R6 R9
    else if (par)     out_x = d ^ x;  // R5
    else              out_x = x;      // R4
    drive(1'b1, d, o, p, e, x);
    #1;
    chk(oh_stb == stb_x, "R7 oh_stb", int'(oh_stb), int'(stb_x));
    chk(oh_pos == (stb_x ? 6'(p) : 6'd0), "R7 oh_pos", int'(oh_pos), stb_x ? p : 0);
    chk(oh_sof == sof_x, "R8 oh_sof", int'(oh_sof), int'(sof_x));
    @(posedge clk);
    #1;
    chk(out_vld == 1'b1, "R2 out_vld", int'(out_vld), 1);
    if (!o)          chk(out_dat == out_x, "R3 payload", int'(out_dat), int'(out_x));
    else if (!legal) chk(out_dat == out_x, "R9 illegal pos", int'(out_dat), int'(out_x));
    else if (!e)     chk(out_dat == out_x, "R6 no ext", int'(out_dat), int'(out_x));
    else if (par)    chk(out_dat == out_x, "R5 parity mask", int'(out_dat), int'(out_x));
    else             chk(out_dat == out_x, "R4 replace", int'(out_dat), int'(out_x));
    chk(out_sof == sof_x, "R8 out_sof", int'(out_sof), int'(sof_x));
  endtask

  task automatic idle_hold(input bit d, input bit e, input bit x);
    bit prev;
    prev = out_dat;
    drive(1'b0, d, 1'b1, 0, e, x);
    #1;
    chk(oh_stb == 1'b0, "R7 idle strobe", int'(oh_stb), 0);
    @(posedge clk);
    #1;
    chk(out_vld == 1'b0, "R2 idle vld", int'(out_vld), 0);
    chk(out_dat == prev, "R2 idle hold", int'(out_dat), int'(prev));
    chk(out_sof == 1'b0, "R8 idle sof", int'(out_sof), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; cycles = 0; done = 1'b0;
    rst_n = 1'b0;
    in_vld = 1'b0; in_dat = 1'b1; in_ohp = 1'b0; in_pos = '0;
    ext_en = 1'b0; ext_dat = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(out_vld == 1'b0, "R1 reset vld", int'(out_vld), 0);
    chk(out_dat == 1'b0, "R1 reset dat", int'(out_dat), 0);
    chk(out_sof == 1'b0, "R1 reset sof", int'(out_sof), 0);
    // Input stimulus during the synchroniser window must not reach outputs.
    @(negedge clk);
    rst_n = 1'b1;
    in_vld = 1'b1; in_ohp = 1'b1;
    @(posedge clk);
    #1;
    chk(out_vld == 1'b0, "R1 sync hold vld", int'(out_vld), 0);
    chk(out_dat == 1'b0, "R1 sync hold dat", int'(out_dat), 0);
    drive(1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);

    // Exhaustive sweep over every position code and bit combination.
    for (int p = 0; p < 64; p++) begin
      for (int d = 0; d < 2; d++) begin
        for (int e = 0; e < 2; e++) begin
          for (int x = 0; x < 2; x++) begin
            send(1'(d), 1'b1, p, 1'(e), 1'(x));
            send(1'(d), 1'b0, p, 1'(e), 1'(x));
          end
        end
      end
      if (p % 8 == 7) begin
        idle_hold(1'(p % 2), 1'b1, 1'b1);
        idle_hold(1'b0, 1'b1, 1'b0);
      end
    end

    // A frame-shaped walk: X1 then payload, with idle gaps between bits.
    for (int k = 0; k < 16; k++) begin
      send(1'(k % 2), (k % 4) == 0, (k % 4) == 0 ? (k / 4) * 8 : k, 1'b1, 1'(k / 2));
      idle_hold(1'b1, 1'b1, 1'(k % 2));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule